// File: doc/BRIEF.md
# Age-Counter Victim Selector

This block tracks how recently each way of a set-associative cache was used and names the way to replace on a miss. It holds a small saturating age per way per set. The age of a way climbs to its ceiling when the way is touched and sinks as other ways are touched. It has no tag or data arrays. The surrounding cache controller gives it a set index and, in any cycle, at most one effective command: record a hit, record a fill, or clear ages for one way or for the whole set. It also reads back the victim way for the indexed set.

The number of age levels (usage states) is a parameter of 2, 3 or 4, so the top age is one less than that count. The victim output is combinational from the stored ages of the set on `set_idx`. A command presented at one clock edge is visible on `victim_way` once that edge has passed.

Top module: `age_victim_tracker`

## Requirements
- R1: Reset clears every age in every set to 0, so the victim of every set is way 0 after reset.
- R2: A hit on way h first lowers by one every other way of that set whose age is above the age of way h. It then sets way h to the top age. A hit on a way that is already at the top age leaves the set unchanged.
- R3: A fill of way f lowers by one every way of that set whose age is nonzero, then sets way f to the top age.
- R4: The victim is the lowest-numbered way holding the smallest age that lies strictly below the top age. If no way qualifies, the victim is way 0.
- R5: Invalidating a single way (`inv_en` with `inv_all` low) sets only that way's age to 0.
- R6: Invalidating a whole set (`inv_en` with `inv_all` high) sets every age of that set to 0.
- R7: Priority within a cycle is hit, then fill, then invalidate. Only the highest-priority asserted command takes effect.
- R8: Commands change only the set selected by `set_idx`. The ages of every other set are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | SET_W | Set addressed by the command and by the victim output |
| hit_en | input | 1 | Record a hit on `hit_way` |
| hit_way | input | WAY_W | Way that hit |
| fill_en | input | 1 | Record a fill of `fill_way` |
| fill_way | input | WAY_W | Way being filled |
| inv_en | input | 1 | Invalidate command |
| inv_all | input | 1 | With `inv_en`: clear the whole set instead of one way |
| inv_way | input | WAY_W | Way cleared by a single-way invalidate |
| victim_way | output | WAY_W | Replacement choice for the set on `set_idx` |

## Verification
The hardest states to reach are those where several ways share the minimum age below the top, because the first-minimum rule only shows up there. A fill or hit spreads the ages apart, so the stimulus first builds a staggered age pattern with a run of fills. It then invalidates a middle way, which leaves it tied with a later way at age 0. The simultaneous hit-and-fill case is chosen so that the two possible outcomes yield different victims. The fill-over-invalidate case is chosen the same way, so a wrong priority shows at the victim output.

// File: rtl/age_victim_tracker.sv
module age_victim_tracker #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int STATES = 4,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int AGE_W = $clog2(STATES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             hit_en,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             inv_en,
  input  logic             inv_all,
  input  logic [WAY_W-1:0] inv_way,
  output logic [WAY_W-1:0] victim_way
);

  localparam logic [AGE_W-1:0] TOP = AGE_W'(STATES - 1);

  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] cur   [WAYS];
  logic [AGE_W-1:0] nxt   [WAYS];
  logic             upd;

  assign upd = hit_en | fill_en | inv_en;

  for (genvar g = 0; g < WAYS; g++) begin : g_rd
    assign cur[g] = age_q[set_idx][g];
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) nxt[w] = cur[w];
    if (hit_en) begin
      for (int w = 0; w < WAYS; w++)
        if (WAY_W'(w) != hit_way && cur[w] > cur[hit_way])
          nxt[w] = cur[w] - AGE_W'(1);
      nxt[hit_way] = TOP;
    end else if (fill_en) begin
      for (int w = 0; w < WAYS; w++)
        if (cur[w] != '0) nxt[w] = cur[w] - AGE_W'(1);
      nxt[fill_way] = TOP;
    end else if (inv_en) begin
      if (inv_all) begin
        for (int w = 0; w < WAYS; w++) nxt[w] = '0;
      end else begin
        nxt[inv_way] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= '0;
    end else if (upd) begin
      for (int w = 0; w < WAYS; w++)
        age_q[set_idx][w] <= nxt[w];
    end
  end

  always_comb begin
    logic [AGE_W-1:0] best;
    best       = TOP;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (cur[w] < best) begin
        best       = cur[w];
        victim_way = WAY_W'(w);
      end
  end

  p_victim_below_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    victim_way != '0 |-> cur[victim_way] < TOP);

  p_hit_sets_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en |=> (set_idx != $past(set_idx)) || (cur[$past(hit_way)] == TOP));

  p_fill_sets_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !hit_en) |=> (set_idx != $past(set_idx)) || (cur[$past(fill_way)] == TOP));

  p_inv_way_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !inv_all && !hit_en && !fill_en) |=>
      (set_idx != $past(set_idx)) || (cur[$past(inv_way)] == '0));

  p_inv_set_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_all && !hit_en && !fill_en) |=>
      (set_idx != $past(set_idx)) || (victim_way == '0 && cur[WAYS-1] == '0));

  p_hit_beats_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && fill_en && fill_way != hit_way) |=>
      (set_idx != $past(set_idx)) || (cur[$past(fill_way)] != TOP));

endmodule

// File: tb/age_victim_tracker_bench.sv
`timescale 1ns/1ps
module age_victim_tracker_bench;
  localparam int SETS = 16, WAYS = 4, STATES = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] set_idx = '0;
  logic       hit_en = 1'b0, fill_en = 1'b0, inv_en = 1'b0, inv_all = 1'b0;
  logic [1:0] hit_way = '0, fill_way = '0, inv_way = '0;
  logic [1:0] victim_way;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  age_victim_tracker #(.SETS(SETS), .WAYS(WAYS), .STATES(STATES)) u_age_victim_tracker (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx),
    .hit_en(hit_en), .hit_way(hit_way),
    .fill_en(fill_en), .fill_way(fill_way),
    .inv_en(inv_en), .inv_all(inv_all), .inv_way(inv_way),
    .victim_way(victim_way));

  // op: 0 idle, 1 hit, 2 fill, 3 inv way, 4 inv set, 5 hit(way)+fill(way2), 6 fill(way)+inv set
  // fields: op[12:10] set[9:6] way[5:4] way2[3:2] expected victim[1:0]
  localparam int NV = 18;
  localparam logic [12:0] VEC [NV] = '{
    {3'd2, 4'd3, 2'd0, 2'd0, 2'd1},
    {3'd2, 4'd3, 2'd1, 2'd0, 2'd2},
    {3'd2, 4'd3, 2'd2, 2'd0, 2'd3},
    {3'd2, 4'd3, 2'd3, 2'd0, 2'd0},
    {3'd1, 4'd3, 2'd1, 2'd0, 2'd0},
    {3'd1, 4'd3, 2'd0, 2'd0, 2'd2},
    {3'd1, 4'd3, 2'd0, 2'd0, 2'd2},
    {3'd2, 4'd3, 2'd2, 2'd0, 2'd3},
    {3'd3, 4'd3, 2'd1, 2'd0, 2'd1},
    {3'd5, 4'd3, 2'd3, 2'd1, 2'd1},
    {3'd1, 4'd3, 2'd1, 2'd0, 2'd0},
    {3'd4, 4'd3, 2'd0, 2'd0, 2'd0},
    {3'd2, 4'd3, 2'd0, 2'd0, 2'd1},
    {3'd2, 4'd5, 2'd2, 2'd0, 2'd0},
    {3'd0, 4'd3, 2'd0, 2'd0, 2'd1},
    {3'd3, 4'd3, 2'd0, 2'd0, 2'd0},
    {3'd6, 4'd3, 2'd0, 2'd0, 2'd1},
    {3'd4, 4'd3, 2'd0, 2'd0, 2'd0}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R2/R4 hit";
      3'd2: return "R3/R4 fill";
      3'd3: return "R5/R4 inv way";
      3'd4: return "R6 inv set";
      3'd5: return "R7 hit over fill";
      3'd6: return "R7 fill over inv";
      default: return "R8 other set untouched";
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (victim_way !== exp) begin
      errors++;
      $display("FAIL %s: victim_way=%0d expected=%0d", req, victim_way, exp);
    end
  endtask

  task automatic apply(input logic [12:0] v);
    @(negedge clk);
    set_idx  = v[9:6];
    hit_en   = (v[12:10] == 3'd1) || (v[12:10] == 3'd5);
    fill_en  = (v[12:10] == 3'd2) || (v[12:10] == 3'd5) || (v[12:10] == 3'd6);
    inv_en   = (v[12:10] == 3'd3) || (v[12:10] == 3'd4) || (v[12:10] == 3'd6);
    inv_all  = (v[12:10] == 3'd4) || (v[12:10] == 3'd6);
    hit_way  = v[5:4];
    fill_way = (v[12:10] == 3'd5) ? v[3:2] : v[5:4];
    inv_way  = v[5:4];
    @(negedge clk);
    hit_en = 1'b0; fill_en = 1'b0; inv_en = 1'b0; inv_all = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: every set reports way 0 after reset
    for (int s = 0; s < SETS; s += 7) begin
      set_idx = 4'(s);
      #1;
      check("R1 reset", 2'd0);
    end
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check(tag_of(VEC[i][12:10]), VEC[i][1:0]);
    end
    // R8: set 5 keeps its own state after set 3 activity
    @(negedge clk); set_idx = 4'd5; #1;
    check("R8 set 5 isolated", 2'd0);
    // R1: reset in mid-run clears a set whose victim was way 1
    apply({3'd2, 4'd3, 2'd0, 2'd0, 2'd1});
    check("R3 fill before reset", 2'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 reset clears ages", 2'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule